// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block turns short event pulses from a transmit FIFO, a receive FIFO and a descriptor engine into sticky status bits. Each status bit passes two gates in series, a per-bit enable and a per-bit signal-enable, and the gated bits are ORed into one interrupt line. Software clears a status bit by writing a 1 to it. A bit whose gates are closed still records its events, so software can poll it.

The block also makes the two FIFO threshold events. It compares the current fill level of each FIFO with a 5-bit threshold that software programs. A pulse on the soft-reset input marks both FIFOs as empty in the status. Software reaches four registers through a simple write strobe and address bus, and read data is returned combinationally.

Register addresses: 0 is status (write 1 to clear), 1 is enable, 2 is signal-enable and 3 is thresholds.

Top module: `intr_sticky_gate`

## Requirements
- R1: While reset is held low, the status, enable and signal-enable registers read 0 and `irq` is low. The threshold register reads 0x0101, meaning both thresholds are 1.
- R2: A 1 on `ev_in` bit 0, 1, 3, 4, 9, 10 or 11 sets the same status bit at the next rising edge. The bit map is: 0 TX empty, 1 TX full, 3 RX empty, 4 RX full, 9 descriptor done, 10 packet complete, 11 DMA error. A set bit stays set until software clears it.
- R3: A write to address 0 clears every status bit that has a 1 in `reg_wdata` and leaves the bits that have a 0. If an event and a clear reach the same bit in the same cycle, the bit ends up set.
- R4: Writes to address 1 (enable) and address 2 (signal-enable) store only the bits that are valid status bits (mask 0xE3F). Reading either address returns the stored value.
- R5: `irq` is high exactly when at least one status bit has its enable bit and its signal-enable bit both set. It follows the registers in the same cycle.
- R6: Status bit 2 (TX threshold) is set at every edge where `tx_level` is at or below the TX threshold. The TX threshold is held in bits 12:8 of address 3.
- R7: Status bit 5 (RX threshold) is set at every edge where `rx_level` is at or above the RX threshold. The RX threshold is held in bits 4:0 of address 3.
- R8: `ev_in` bits 2, 5, 6, 7 and 8 have no effect. Status bits 6 to 8 always read 0.
- R9: A pulse on `soft_rst` sets status bits 0 and 3 (both FIFOs empty) at the next edge.
- R10: A status bit whose enable or signal-enable is 0 still records events and reads back as 1, but it does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| ev_in | input | 12 | Event pulses, one bit per status position |
| soft_rst | input | 1 | Soft-reset pulse |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| irq | output | 1 | Gated interrupt line |

## Verification
Events, threshold conditions and register writes are sampled at a rising edge, and their effect shows up after that one edge. Read data and `irq` are combinational from the registers, so they show the new state with no further delay. The bench changes its inputs at the falling edge and compares `reg_rdata` and `irq` 1 ns later against a model that has already applied every edge so far. It then updates the model with the inputs that the coming edge will capture. This means every comparison lands exactly one edge after its stimulus.

// File: rtl/intr_gate_pkg.sv
`timescale 1ns/1ps
// Shared constants for the sticky interrupt controller: the status bit map,
// the masks derived from it and the register addresses.
// Assumes a 12-bit status vector whose bit positions are fixed by software.
package intr_gate_pkg;
    localparam int STAT_W  = 12;
    localparam int THR_W   = 5;

    // status bit positions
    localparam int B_TXE   = 0;
    localparam int B_TXF   = 1;
    localparam int B_TXT   = 2;
    localparam int B_RXE   = 3;
    localparam int B_RXF   = 4;
    localparam int B_RXT   = 5;
    localparam int B_BDONE = 9;
    localparam int B_PKT   = 10;
    localparam int B_DERR  = 11;

    // bits that exist in the status vector
    localparam logic [STAT_W-1:0] VALID_MASK = STAT_W'((1 << B_TXE) | (1 << B_TXF) | (1 << B_TXT) |
                                                       (1 << B_RXE) | (1 << B_RXF) | (1 << B_RXT) |
                                                       (1 << B_BDONE) | (1 << B_PKT) | (1 << B_DERR));
    // bits that the external event pulses may set
    localparam logic [STAT_W-1:0] EVT_MASK   = STAT_W'((1 << B_TXE) | (1 << B_TXF) | (1 << B_RXE) |
                                                       (1 << B_RXF) | (1 << B_BDONE) | (1 << B_PKT) |
                                                       (1 << B_DERR));
    // bits that the soft-reset pulse sets (both FIFOs empty)
    localparam logic [STAT_W-1:0] SOFT_MASK  = STAT_W'((1 << B_TXE) | (1 << B_RXE));

    // register addresses
    localparam logic [1:0] A_STAT = 2'd0;
    localparam logic [1:0] A_EN   = 2'd1;
    localparam logic [1:0] A_SIG  = 2'd2;
    localparam logic [1:0] A_THR  = 2'd3;

    // threshold field positions and reset value
    localparam int TX_LSB = 8;
    localparam int RX_LSB = 0;
    localparam logic [THR_W-1:0] THR_RST = THR_W'(1);
endpackage

// File: rtl/intr_thr_detect.sv
`timescale 1ns/1ps
// Compares the FIFO fill levels with the programmed thresholds.
// Assumes LVL_W is wider than THR_W; the thresholds are zero-extended.
module intr_thr_detect #(
    parameter int LVL_W = 6,
    parameter int THR_W = 5
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    output logic             tx_hit,
    output logic             rx_hit
);
    localparam int PAD_W = LVL_W - THR_W;

    logic [LVL_W-1:0] tx_thr_ext;
    logic [LVL_W-1:0] rx_thr_ext;

    // TX fires at or below its threshold, RX at or above its threshold
    always_comb begin
        tx_thr_ext = {{PAD_W{1'b0}}, tx_thr};
        rx_thr_ext = {{PAD_W{1'b0}}, rx_thr};
        tx_hit     = (tx_level <= tx_thr_ext);
        rx_hit     = (rx_level >= rx_thr_ext);
    end
endmodule

// File: rtl/intr_stat_bank.sv
`timescale 1ns/1ps
// Sticky status bits: set by event masks, cleared by a write-one-to-clear mask.
// When a bit is set and cleared in the same cycle, the set wins.
// Assumes set_mask has already been reduced to the valid bit positions.
module intr_stat_bank
    import intr_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_mask,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] stat_q
);
    // hold, clear and set the sticky bits
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= ((stat_q & ~clr_mask) | set_mask) & VALID_MASK;
    end

    // R2: a set bit survives unless its clear bit was written
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q != '0) |=> (((stat_q | $past(clr_mask)) & $past(stat_q)) == $past(stat_q)));

    // R3: an event sets its bit even when a clear arrives at the same edge
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((stat_q & $past(set_mask)) == $past(set_mask)));

    // R8: positions outside the bit map never read as set
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~VALID_MASK) == '0);
endmodule

// File: rtl/intr_gate.sv
`timescale 1ns/1ps
// Two-level gate: for each bit, status AND enable AND signal-enable, then all bits ORed.
// Assumes all three vectors share the same bit map.
module intr_gate
    import intr_gate_pkg::*;
(
    input  logic [STAT_W-1:0] stat,
    input  logic [STAT_W-1:0] en,
    input  logic [STAT_W-1:0] sig,
    output logic              irq
);
    logic [STAT_W-1:0] pass;

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        // a bit passes only when both gates are open
        assign pass[i] = stat[i] & en[i] & sig[i];
    end

    // reduce the passing bits onto the line
    assign irq = |pass;
endmodule

// File: rtl/intr_sticky_gate.sv
`timescale 1ns/1ps
// Top of the sticky interrupt controller. It holds the enable, signal-enable and
// threshold registers, builds the event set mask and returns read data combinationally.
// Assumes a single-cycle write strobe. Reads have no side effects.
module intr_sticky_gate
    import intr_gate_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [STAT_W-1:0] ev_in,
    input  logic              soft_rst,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              irq
);
    localparam int USED_W = TX_LSB + THR_W;

    logic [STAT_W-1:0] en_q;
    logic [STAT_W-1:0] sig_q;
    logic [THR_W-1:0]  tx_thr_q;
    logic [THR_W-1:0]  rx_thr_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] set_mask;
    logic [STAT_W-1:0] clr_mask;
    logic              tx_hit;
    logic              rx_hit;
    logic              wdata_unused;

    assign wdata_unused = ^reg_wdata[DATA_W-1:USED_W];

    // gate and threshold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            sig_q    <= '0;
            tx_thr_q <= THR_RST;
            rx_thr_q <= THR_RST;
        end else if (reg_wr) begin
            case (reg_addr)
                A_EN:  en_q  <= reg_wdata[STAT_W-1:0] & VALID_MASK;
                A_SIG: sig_q <= reg_wdata[STAT_W-1:0] & VALID_MASK;
                A_THR: begin
                    tx_thr_q <= reg_wdata[TX_LSB +: THR_W];
                    rx_thr_q <= reg_wdata[RX_LSB +: THR_W];
                end
                default: ;
            endcase
        end
    end

    intr_thr_detect #(.LVL_W(LVL_W), .THR_W(THR_W)) u_thr (
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_thr   (tx_thr_q),
        .rx_thr   (rx_thr_q),
        .tx_hit   (tx_hit),
        .rx_hit   (rx_hit)
    );

    // gather the sources that set status and the write-one-to-clear mask
    always_comb begin
        set_mask         = (ev_in & EVT_MASK) | (soft_rst ? SOFT_MASK : '0);
        set_mask[B_TXT]  = tx_hit;
        set_mask[B_RXT]  = rx_hit;
        clr_mask         = (reg_wr && reg_addr == A_STAT) ? reg_wdata[STAT_W-1:0] : '0;
    end

    intr_stat_bank u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .stat_q   (stat_q)
    );

    intr_gate u_gate (
        .stat (stat_q),
        .en   (en_q),
        .sig  (sig_q),
        .irq  (irq)
    );

    // select the register that is read
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STAT: reg_rdata[STAT_W-1:0] = stat_q;
            A_EN:   reg_rdata[STAT_W-1:0] = en_q;
            A_SIG:  reg_rdata[STAT_W-1:0] = sig_q;
            default: begin
                reg_rdata[TX_LSB +: THR_W] = tx_thr_q;
                reg_rdata[RX_LSB +: THR_W] = rx_thr_q;
            end
        endcase
    end

    // R5: the line needs at least one open gate of each kind
    a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_q != '0 && sig_q != '0));

    // R6: TX threshold condition lands in status at the next edge
    a_r6_tx_thr: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LVL_W'(tx_thr_q)) |=> stat_q[B_TXT]);

    // R7: RX threshold condition lands in status at the next edge
    a_r7_rx_thr: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= LVL_W'(rx_thr_q)) |=> stat_q[B_RXT]);

    // R9: soft reset marks both FIFOs empty
    a_r9_soft: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ((stat_q & SOFT_MASK) == SOFT_MASK));
endmodule

// File: tb/intr_sticky_gate_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases followed by seeded random traffic,
// compared against a bench-side model of the register state.
module intr_sticky_gate_test;
    localparam int DW = 16;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [11:0]   ev_in = '0;
    logic          soft_rst = 1'b0;
    logic [LW-1:0] tx_level = LW'(40);
    logic [LW-1:0] rx_level = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;

    logic [11:0] m_stat, m_en, m_sig;
    logic [4:0]  m_tx, m_rx;

    always #2 clk = ~clk;

    intr_sticky_gate uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev_in),
        .soft_rst(soft_rst), .tx_level(tx_level), .rx_level(rx_level), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    exp_rd = {20'd0, m_stat};
            2'd1:    exp_rd = {20'd0, m_en};
            2'd2:    exp_rd = {20'd0, m_sig};
            default: exp_rd = (32'(m_tx) << 8) | 32'(m_rx);
        endcase
    endfunction

    function automatic logic exp_irq();
        exp_irq = |(m_stat & m_en & m_sig);
    endfunction

    // one cycle: called at a falling edge; drive, check the current state, advance the model
    task automatic cyc(input string req, input logic wr, input logic [1:0] a, input logic [DW-1:0] wd,
                       input logic [11:0] ev, input logic sr, input int txl, input int rxl);
        logic [11:0] set, clr;
        reg_wr = wr; reg_addr = a; reg_wdata = wd; ev_in = ev; soft_rst = sr;
        tx_level = LW'(txl); rx_level = LW'(rxl);
        #1;
        chk(req, 32'(reg_rdata), exp_rd(a));
        chk("R5", 32'(irq), 32'(exp_irq()));
        set = (ev & 12'hE1B) | (sr ? 12'h009 : 12'h000);
        if (txl <= int'(m_tx)) set[2] = 1'b1;
        if (rxl >= int'(m_rx)) set[5] = 1'b1;
        clr = (wr && a == 2'd0) ? wd[11:0] : 12'h000;
        m_stat = (m_stat & ~clr) | set;
        if (wr && a == 2'd1) m_en  = wd[11:0] & 12'hE3F;
        if (wr && a == 2'd2) m_sig = wd[11:0] & 12'hE3F;
        if (wr && a == 2'd3) begin m_tx = wd[12:8]; m_rx = wd[4:0]; end
        @(negedge clk);
    endtask

    // quiet read: levels chosen so that no threshold event fires with the default thresholds
    task automatic rd(input string req, input logic [1:0] a);
        cyc(req, 1'b0, a, '0, '0, 1'b0, 40, 0);
    endtask

    task automatic wr(input string req, input logic [1:0] a, input logic [DW-1:0] d);
        cyc(req, 1'b1, a, d, '0, 1'b0, 40, 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_stat = '0; m_en = '0; m_sig = '0; m_tx = 5'd1; m_rx = 5'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state held in reset
        reg_addr = 2'd0; #1; chk("R1", 32'(reg_rdata), 32'h0); chk("R1", 32'(irq), 32'h0);
        reg_addr = 2'd1; #1; chk("R1", 32'(reg_rdata), 32'h0);
        reg_addr = 2'd2; #1; chk("R1", 32'(reg_rdata), 32'h0);
        reg_addr = 2'd3; #1; chk("R1", 32'(reg_rdata), 32'h0101);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: event sets its bit, and the bit stays set
        cyc("R2", 1'b0, 2'd0, '0, 12'h200, 1'b0, 40, 0);
        rd("R2", 2'd0);
        rd("R2", 2'd0);
        chk("R2", 32'(m_stat), 32'h200);
        // R3: writing 0 keeps the bit, set beats clear, writing 1 clears
        wr("R3", 2'd0, 16'h0000);
        rd("R3", 2'd0);
        cyc("R3", 1'b1, 2'd0, 16'h0200, 12'h200, 1'b0, 40, 0);
        rd("R3", 2'd0);
        wr("R3", 2'd0, 16'h0200);
        rd("R3", 2'd0);
        chk("R3", 32'(m_stat), 32'h0);
        // R8: ignored event positions
        cyc("R8", 1'b0, 2'd0, '0, 12'h1E4, 1'b0, 40, 0);
        rd("R8", 2'd0);
        // R4: enable and signal-enable keep only valid bits
        wr("R4", 2'd1, 16'hFFFF);
        rd("R4", 2'd1);
        chk("R4", 32'(m_en), 32'hE3F);
        wr("R4", 2'd2, 16'h0000);
        // R10: signal-enable closed, event recorded, irq stays low
        cyc("R10", 1'b0, 2'd0, '0, 12'h800, 1'b0, 40, 0);
        rd("R10", 2'd0);
        wr("R5", 2'd2, 16'h0800);
        rd("R5", 2'd0);
        chk("R5", 32'(exp_irq()), 32'h1);
        wr("R10", 2'd1, 16'h0000);
        rd("R10", 2'd0);
        chk("R10", 32'(m_stat), 32'h800);
        wr("R3", 2'd0, 16'hFFFF);
        // R6/R7 thresholds: TX 5, RX 7
        wr("R6", 2'd3, 16'h0507);
        cyc("R6", 1'b1, 2'd0, 16'h0FFF, '0, 1'b0, 6, 6);
        cyc("R6", 1'b0, 2'd0, '0, '0, 1'b0, 6, 6);
        cyc("R6", 1'b0, 2'd0, '0, '0, 1'b0, 5, 6);
        cyc("R6", 1'b0, 2'd0, '0, '0, 1'b0, 40, 0);
        chk("R6", 32'(m_stat), 32'h004);
        cyc("R7", 1'b1, 2'd0, 16'h0FFF, '0, 1'b0, 40, 7);
        cyc("R7", 1'b0, 2'd0, '0, '0, 1'b0, 40, 0);
        chk("R7", 32'(m_stat), 32'h020);
        wr("R3", 2'd0, 16'hFFFF);
        // R9: soft reset marks both FIFOs empty
        cyc("R9", 1'b0, 2'd0, '0, '0, 1'b1, 40, 0);
        rd("R9", 2'd0);
        chk("R9", 32'(m_stat), 32'h009);

        // seeded random traffic
        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            logic w;
            logic [1:0] a;
            logic [DW-1:0] d;
            logic [11:0] e;
            w = ($urandom_range(0, 5) == 0);
            a = 2'($urandom_range(0, 3));
            d = DW'($urandom);
            if (w && a == 2'd0 && $urandom_range(0, 3) == 0) d = '1;
            e = 12'($urandom) & 12'($urandom) & 12'($urandom);
            cyc(a == 2'd0 ? "R2" : (a == 2'd3 ? "R6" : "R4"), w, a, d, e,
                ($urandom_range(0, 30) == 0), $urandom_range(0, 33), $urandom_range(0, 33));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule